// File: doc/BRIEF.md
# Fixed-Burst Stream-to-Memory Write Engine

This block moves a stream of data words into memory, one transfer per command. It takes a command (start address, length in bytes, address-increment flag) from an upstream command queue. It accepts the matching words from a streaming sink port into an internal buffer, then drains the buffer through a memory-mapped write master. The drain uses bursts of a fixed length: every burst carries exactly `BURST_WORDS` beats, except the last burst of a command, which carries whatever is left.

A burst is launched only when all of its beats are already buffered. Once launched, it can therefore never stall on missing data; only the memory side's wait request can hold it. The buffer holds two bursts, so the next burst can fill while the current one drains. A transfer can be cut short by an end-of-packet marker on the sink. When the transfer finishes, a one-cycle status token reports how many bytes actually reached memory.

Top module: `burst_write_dma`

## Requirements
- R1: While reset is held and after it is released with no command pending, `m_write` and `sts_valid` are 0, `cmd_ready` is 1 and `snk_ready` is 0.
- R2: Only one command is in progress at a time. `cmd_ready` is 1 only while no command is active, and a command is taken on a cycle with `cmd_valid` and `cmd_ready` both high.
- R3: The internal buffer holds 2*`BURST_WORDS` words, plus one word held in the output data register. When the buffer is full, `snk_ready` is 0. If memory stalls indefinitely, exactly 2*`BURST_WORDS`+1 words of a long command are accepted.
- R4: For a command of N words, beats are grouped into bursts. Every burst except the last presents `m_burstcount` = `BURST_WORDS`, and `m_burstcount` is never 0 nor above `BURST_WORDS`.
- R5: The last burst of a command presents `m_burstcount` = N mod `BURST_WORDS`, or `BURST_WORDS` when the remainder is 0. A burst shorter than `BURST_WORDS` starts only after every word of the command has been accepted from the sink.
- R6: A burst starts only when all of its beats are already buffered.
- R7: The command length is in bytes and is a multiple of `DATA_W`/8; its low bits are ignored. When `cmd_incr` is 1, beat k of a command is written at start address + k*(`DATA_W`/8). When `cmd_incr` is 0, every beat goes to the start address.
- R8: Beats carry the sink words in the order the sink delivered them.
- R9: While `m_write` is 1 and `m_waitrequest` is 1, `m_write`, `m_addr`, `m_burstcount` and `m_data` hold their values into the next cycle. A beat completes on a clock edge with `m_write` = 1 and `m_waitrequest` = 0.
- R10: If `snk_eop` is 1 on an accepted word before the command length is reached, the command ends after that word. `snk_ready` stays 0 for the rest of the command, and the status reports the shorter count.
- R11: Once the last beat of a command completes, `sts_valid` pulses for exactly one cycle with `sts_bytes` = beats written * (`DATA_W`/8). A zero-length command produces this pulse with 0 and no write.
- R12: `snk_ready` is 1 only while a command is active and it still has words to receive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command queue not empty |
| cmd_ready | output | 1 | Command taken this cycle when valid is high |
| cmd_addr | input | ADDR_W | Start byte address |
| cmd_bytes | input | LEN_W | Transfer length in bytes |
| cmd_incr | input | 1 | 1: advance address every beat; 0: fixed address |
| snk_valid | input | 1 | Sink word valid |
| snk_ready | output | 1 | Sink word accepted when valid is high |
| snk_data | input | DATA_W | Sink data word |
| snk_eop | input | 1 | Last word of the packet |
| m_write | output | 1 | Write request |
| m_addr | output | ADDR_W | Beat address |
| m_burstcount | output | $clog2(BURST_WORDS+1) | Beats in the current burst |
| m_data | output | DATA_W | Write data |
| m_waitrequest | input | 1 | Memory stalls the current beat |
| sts_valid | output | 1 | One-cycle status pulse |
| sts_bytes | output | LEN_W | Bytes written by the finished command |

## Verification
Lengths of whole multiples of the burst, lengths with a remainder, lengths shorter than one burst, one word, and zero words are applied. Together they separate the full-burst grouping from the short-burst grouping and the empty case. Early end-of-packet cuts are placed both inside a burst and exactly on a burst boundary, which shows whether the cut count reaches both the burst sizing and the status. The same set is run with no back-pressure and then with random memory stalls and sink gaps, so that grouping that depends on timing is distinguished from grouping that depends on length. A held stall on a long command measures the buffer capacity directly.

// File: rtl/wdma_pkg.sv
package wdma_pkg;
  typedef enum logic {
    CS_IDLE,
    CS_RUN
  } cmd_state_e;
endpackage

// File: rtl/wdma_fifo.sv
module wdma_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] pop_data,
  output logic [CNT_W-1:0]  count,
  output logic              full
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr, wr_nxt, rd_nxt;

  generate
    if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign wr_nxt = wr_ptr + PTR_W'(1);
      assign rd_nxt = rd_ptr + PTR_W'(1);
    end else begin : g_wrap
      assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
      assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
    end
  endgenerate

  // storage and registered read port, no reset: block RAM friendly
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (pop) pop_data <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= wr_nxt;
      if (pop)  rd_ptr <= rd_nxt;
      case ({push, pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  assign full = (count == CNT_W'(DEPTH));

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) push |-> count < CNT_W'(DEPTH)); // R3
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst) pop |-> count != '0); // R6
endmodule

// File: rtl/wdma_intake.sv
module wdma_intake #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [LEN_W-1:0] load_words,
  input  logic             active,
  input  logic             fifo_full,
  input  logic             snk_valid,
  input  logic             snk_eop,
  output logic             snk_ready,
  output logic             push,
  output logic             all_in
);
  logic [LEN_W-1:0] recv_left;
  logic             eop_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      recv_left <= '0;
      eop_done  <= 1'b0;
    end else if (load) begin
      recv_left <= load_words;
      eop_done  <= 1'b0;
    end else if (push) begin
      recv_left <= recv_left - LEN_W'(1);
      if (snk_eop) eop_done <= 1'b1;
    end
  end

  assign all_in    = (recv_left == '0) || eop_done;
  assign snk_ready = active && !all_in && !fifo_full;
  assign push      = snk_valid && snk_ready;

  AST_EOP_STOPS: assert property (@(posedge clk) disable iff (rst) (push && snk_eop) |=> !snk_ready); // R10
  AST_READY_ACTIVE: assert property (@(posedge clk) disable iff (rst) snk_ready |-> active); // R12
endmodule

// File: rtl/wdma_burst_master.sv
module wdma_burst_master #(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 16,
  parameter int BURST     = 4,
  parameter int ADDR_STEP = 4,
  parameter int CNT_W     = 4,
  localparam int BC_W     = $clog2(BURST + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              load_incr,
  input  logic              active,
  input  logic              all_in,
  input  logic [CNT_W-1:0]  fifo_count,
  input  logic              m_waitrequest,
  output logic              pop,
  output logic              m_write,
  output logic [ADDR_W-1:0] m_addr,
  output logic [BC_W-1:0]   m_burstcount,
  output logic [LEN_W-1:0]  written,
  output logic              drained
);
  logic [BC_W-1:0] beats_left;
  logic [BC_W-1:0] bc_next;
  logic            incr_q;
  logic            full_ready;
  logic            start;
  logic            beat;

  assign full_ready = fifo_count >= CNT_W'(BURST);
  assign start      = active && !m_write && (full_ready || (all_in && fifo_count != '0));
  assign bc_next    = full_ready ? BC_W'(BURST) : BC_W'(fifo_count);
  assign beat       = m_write && !m_waitrequest;
  assign pop        = start || (beat && beats_left != BC_W'(1));
  assign drained    = active && all_in && (fifo_count == '0) && !m_write;

  always_ff @(posedge clk) begin
    if (rst) begin
      m_write      <= 1'b0;
      m_addr       <= '0;
      m_burstcount <= '0;
      beats_left   <= '0;
      incr_q       <= 1'b0;
      written      <= '0;
    end else begin
      if (load) begin
        m_addr  <= load_addr;
        incr_q  <= load_incr;
        written <= '0;
      end
      if (start) begin
        m_write      <= 1'b1;
        m_burstcount <= bc_next;
        beats_left   <= bc_next;
      end
      if (beat) begin
        written    <= written + LEN_W'(1);
        beats_left <= beats_left - BC_W'(1);
        if (incr_q) m_addr <= m_addr + ADDR_W'(ADDR_STEP);
        if (beats_left == BC_W'(1)) m_write <= 1'b0;
      end
    end
  end

  AST_HOLD_WAIT: assert property (@(posedge clk) disable iff (rst) (m_write && m_waitrequest) |=> (m_write && $stable(m_addr) && $stable(m_burstcount))); // R9
  AST_BURST_BUFFERED: assert property (@(posedge clk) disable iff (rst) $rose(m_write) |-> $past(fifo_count) >= CNT_W'(m_burstcount)); // R6
  AST_SHORT_LAST: assert property (@(posedge clk) disable iff (rst) ($rose(m_write) && m_burstcount < BC_W'(BURST)) |-> all_in); // R5
  AST_BURST_RANGE: assert property (@(posedge clk) disable iff (rst) m_write |-> (m_burstcount != '0 && m_burstcount <= BC_W'(BURST))); // R4
endmodule

// File: rtl/burst_write_dma.sv
module burst_write_dma #(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int LEN_W       = 16,
  parameter int BURST_WORDS = 4,
  localparam int BC_W       = $clog2(BURST_WORDS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [LEN_W-1:0]  cmd_bytes,
  input  logic              cmd_incr,
  input  logic              snk_valid,
  output logic              snk_ready,
  input  logic [DATA_W-1:0] snk_data,
  input  logic              snk_eop,
  output logic              m_write,
  output logic [ADDR_W-1:0] m_addr,
  output logic [BC_W-1:0]   m_burstcount,
  output logic [DATA_W-1:0] m_data,
  input  logic              m_waitrequest,
  output logic              sts_valid,
  output logic [LEN_W-1:0]  sts_bytes
);
  import wdma_pkg::*;

  localparam int BYTES_PER_WORD = DATA_W / 8;
  localparam int BSHIFT         = $clog2(BYTES_PER_WORD);
  localparam int DEPTH          = 2 * BURST_WORDS;
  localparam int CNT_W          = $clog2(DEPTH + 1);

  cmd_state_e       state;
  logic             load;
  logic             active;
  logic             push;
  logic             pop;
  logic             all_in;
  logic             fifo_full;
  logic [CNT_W-1:0] fifo_count;
  logic [LEN_W-1:0] written;
  logic             drained;
  logic [LEN_W-1:0] cmd_words;

  assign cmd_ready = (state == CS_IDLE);
  assign active    = (state == CS_RUN);
  assign load      = cmd_valid && cmd_ready;
  assign cmd_words = cmd_bytes >> BSHIFT;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= CS_IDLE;
      sts_valid <= 1'b0;
      sts_bytes <= '0;
    end else begin
      sts_valid <= 1'b0;
      case (state)
        CS_IDLE: if (load) state <= CS_RUN;
        CS_RUN: begin
          if (drained) begin
            sts_valid <= 1'b1;
            sts_bytes <= written << BSHIFT;
            state     <= CS_IDLE;
          end
        end
        default: state <= CS_IDLE;
      endcase
    end
  end

  wdma_intake #(.LEN_W(LEN_W)) u_intake (
    .clk        (clk),
    .rst        (rst),
    .load       (load),
    .load_words (cmd_words),
    .active     (active),
    .fifo_full  (fifo_full),
    .snk_valid  (snk_valid),
    .snk_eop    (snk_eop),
    .snk_ready  (snk_ready),
    .push       (push),
    .all_in     (all_in)
  );

  wdma_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .push      (push),
    .push_data (snk_data),
    .pop       (pop),
    .pop_data  (m_data),
    .count     (fifo_count),
    .full      (fifo_full)
  );

  wdma_burst_master #(
    .ADDR_W    (ADDR_W),
    .LEN_W     (LEN_W),
    .BURST     (BURST_WORDS),
    .ADDR_STEP (BYTES_PER_WORD),
    .CNT_W     (CNT_W)
  ) u_master (
    .clk           (clk),
    .rst           (rst),
    .load          (load),
    .load_addr     (cmd_addr),
    .load_incr     (cmd_incr),
    .active        (active),
    .all_in        (all_in),
    .fifo_count    (fifo_count),
    .m_waitrequest (m_waitrequest),
    .pop           (pop),
    .m_write       (m_write),
    .m_addr        (m_addr),
    .m_burstcount  (m_burstcount),
    .written       (written),
    .drained       (drained)
  );

  AST_CMD_IDLE: assert property (@(posedge clk) disable iff (rst) cmd_ready |-> !m_write); // R2
  AST_STS_PULSE: assert property (@(posedge clk) disable iff (rst) sts_valid |=> !sts_valid); // R11
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst) (m_write && m_waitrequest) |=> $stable(m_data)); // R9
endmodule

// File: tb/test_burst_write_dma.sv
`timescale 1ns/1ps
module test_burst_write_dma;
  localparam int B   = 4;
  localparam int BPW = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0, cmd_ready;
  logic [31:0] cmd_addr = '0;
  logic [15:0] cmd_bytes = '0;
  logic        cmd_incr = 1'b0;
  logic        snk_valid = 1'b0, snk_ready;
  logic [31:0] snk_data = '0;
  logic        snk_eop = 1'b0;
  logic        m_write;
  logic [31:0] m_addr;
  logic [2:0]  m_burstcount;
  logic [31:0] m_data;
  logic        m_waitrequest = 1'b0;
  logic        sts_valid;
  logic [15:0] sts_bytes;

  burst_write_dma #(.ADDR_W(32), .DATA_W(32), .LEN_W(16), .BURST_WORDS(B)) i_burst_write_dma (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
    .cmd_bytes(cmd_bytes), .cmd_incr(cmd_incr),
    .snk_valid(snk_valid), .snk_ready(snk_ready), .snk_data(snk_data), .snk_eop(snk_eop),
    .m_write(m_write), .m_addr(m_addr), .m_burstcount(m_burstcount), .m_data(m_data),
    .m_waitrequest(m_waitrequest), .sts_valid(sts_valid), .sts_bytes(sts_bytes)
  );

  always #10 clk = ~clk;

  typedef struct { logic [31:0] addr; int words; bit incr; int eff; } cmd_t;
  typedef struct { logic [31:0] d; bit eop; } word_t;

  cmd_t        pend[$];
  word_t       sq[$];
  logic [31:0] dq[$];
  int vectors = 0, fails = 0;
  int wmode = 0, vmode = 0;
  bit busy = 0, done = 0;
  cmd_t act;
  int k = 0, rx_cnt = 0, seq = 0;
  bit prev_wait = 0;
  logic [31:0] p_addr, p_data;
  logic [2:0]  p_bc;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint actv, input longint expv);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, actv, expv);
    end
  endtask

  task automatic add_cmd(input logic [31:0] a, input int words, input bit inc, input int eop_at);
    cmd_t c;
    c.addr = a; c.words = words; c.incr = inc;
    c.eff = (eop_at > 0) ? eop_at : words;
    pend.push_back(c);
    for (int j = 0; j < c.eff; j++) begin
      word_t w;
      w.d = 32'hA500_0000 + seq; w.eop = (j == c.eff - 1);
      seq++;
      sq.push_back(w);
    end
  endtask

  task automatic run_set();
    add_cmd(32'h0000_1000, 8, 1, 0);   // two full bursts
    add_cmd(32'h0000_2000, 6, 1, 0);   // full + short
    add_cmd(32'h0000_3000, 3, 0, 0);   // short only, fixed address
    add_cmd(32'h0000_4000, 4, 1, 0);   // exactly one burst
    add_cmd(32'h0000_5000, 0, 1, 0);   // empty command
    add_cmd(32'h0000_6000, 10, 1, 7);  // early end inside burst
    add_cmd(32'h0000_7000, 5, 1, 4);   // early end on boundary
    add_cmd(32'h0000_8000, 1, 0, 0);   // single word
    add_cmd(32'h0000_9000, 13, 1, 0);
    add_cmd(32'h0000_A000, 9, 0, 0);
    add_cmd(32'h0000_B000, 12, 1, 2);
  endtask

  task automatic wait_idle();
    while (pend.size() != 0 || busy || sq.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    end
  endtask

  // driver and cycle-by-cycle reference comparison
  initial begin
    forever begin
      @(negedge clk);
      if (rst) begin
        cmd_valid = 0; snk_valid = 0; m_waitrequest = 0; prev_wait = 0;
        continue;
      end
      cmd_valid = (pend.size() != 0);
      if (cmd_valid) begin
        cmd_addr  = pend[0].addr;
        cmd_bytes = 16'(pend[0].words * BPW);
        cmd_incr  = pend[0].incr;
      end
      snk_valid = (sq.size() != 0) && (vmode == 0 || $urandom_range(0, 9) < 7);
      if (sq.size() != 0) begin snk_data = sq[0].d; snk_eop = sq[0].eop; end
      m_waitrequest = (wmode == 2) ? 1'b1 : (wmode == 1) ? ($urandom_range(0, 3) == 0) : 1'b0;
      #1;
      if (prev_wait)
        chk(m_write && m_addr == p_addr && m_burstcount == p_bc && m_data == p_data,
            "R9", "outputs held under waitrequest", {m_write, m_addr}, {1'b1, p_addr});
      if (sts_valid) begin
        if (!busy) chk(0, "R11", "status with no command", 1, 0);
        else begin
          chk(sts_bytes == 16'(act.eff * BPW), (act.eff < act.words) ? "R10" : "R11",
              "status byte count", sts_bytes, act.eff * BPW);
          chk(k == act.eff, "R11", "beats before status", k, act.eff);
        end
        busy = 0;
      end
      if (!busy && snk_ready) chk(0, "R12", "sink ready while idle", 1, 0);
      if (busy && cmd_ready) chk(0, "R2", "command ready while busy", 1, 0);
      if (cmd_valid && cmd_ready) begin
        act = pend.pop_front(); busy = 1; k = 0; rx_cnt = 0;
      end
      if (snk_valid && snk_ready) begin
        if (rx_cnt >= act.eff) chk(0, "R10", "word taken past command end", rx_cnt, act.eff);
        dq.push_back(sq[0].d);
        void'(sq.pop_front());
        rx_cnt++;
      end
      if (m_write && !busy) chk(0, "R2", "write with no command", 1, 0);
      if (m_write && !m_waitrequest && busy) begin
        if (k >= act.eff) chk(0, "R10", "extra beat", k, act.eff);
        else begin
          int j0, ebc;
          j0 = (k / B) * B;
          ebc = (act.eff - j0 < B) ? act.eff - j0 : B;
          chk(m_burstcount == 3'(ebc), (ebc == B) ? "R4" : "R5", "burst count", m_burstcount, ebc);
          if (k % B == 0) begin
            chk(rx_cnt - k >= ebc, "R6", "buffered words at burst start", rx_cnt - k, ebc);
            if (ebc < B) chk(rx_cnt == act.eff, "R5", "short burst before all words in", rx_cnt, act.eff);
          end
          chk(m_addr == act.addr + (act.incr ? 32'(k * BPW) : 32'd0), "R7", "beat address",
              m_addr, act.addr + (act.incr ? 32'(k * BPW) : 32'd0));
          if (dq.size() == 0) chk(0, "R8", "beat with no data sent", m_data, 0);
          else begin
            logic [31:0] ed;
            ed = dq.pop_front();
            chk(m_data == ed, "R8", "beat data", m_data, ed);
          end
        end
        k++;
      end
      prev_wait = m_write && m_waitrequest;
      p_addr = m_addr; p_bc = m_burstcount; p_data = m_data;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R11 watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst = 1;
    repeat (3) @(negedge clk);
    #2;
    chk(m_write == 0, "R1", "m_write in reset", m_write, 0);
    chk(sts_valid == 0, "R1", "sts_valid in reset", sts_valid, 0);
    chk(cmd_ready == 1, "R1", "cmd_ready in reset", cmd_ready, 1);
    chk(snk_ready == 0, "R1", "snk_ready in reset", snk_ready, 0);
    @(negedge clk);
    rst = 0;
    @(negedge clk); #2;
    chk(cmd_ready == 1 && snk_ready == 0 && m_write == 0, "R1", "idle after reset",
        {cmd_ready, snk_ready, m_write}, 3'b100);

    wmode = 0; vmode = 0;
    run_set();
    wait_idle();

    wmode = 1; vmode = 1;
    run_set();
    wait_idle();

    // held stall measures buffer capacity
    wmode = 2; vmode = 0;
    add_cmd(32'h0001_0000, 20, 1, 0);
    repeat (40) @(negedge clk);
    #2;
    chk(rx_cnt == 2 * B + 1, "R3", "words accepted under stall", rx_cnt, 2 * B + 1);
    chk(snk_ready == 0, "R3", "sink ready with buffer full", snk_ready, 0);
    chk(m_write == 1 && m_burstcount == 3'(B), "R9", "burst held under stall",
        {m_write, m_burstcount}, {1'b1, 3'(B)});
    wmode = 0;
    wait_idle();

    summary();
    $finish;
  end
endmodule